// File: doc/BRIEF.md
# Flash Controller Interrupt Status Unit

This unit gathers event pulses from a NAND flash controller and condenses them into a single active-high, level-sensitive interrupt line. Six events are tracked: flash device ready, controller ready, decode failure, decode error, ECC ready and write-protect fault. Each event sets a bit in a sticky status register. A 6-bit enable mask selects which sticky bits may raise the interrupt. A bus read of the sticky register returns its contents and clears every bit in the same access. Software therefore services the interrupt by reading that register once.

A second, read-only live register reports the current state of the block's sources. It is not sticky, and its bits are in a different order: the ready levels, an errors-detected flag, a decoder-failure flag and a 2-bit field holding the corrected-symbol count minus one. The flash-ready source may settle later than its event pulse, so software polls the live register after the interrupt has fired.

Access is through a simple register bus. Reads return data one cycle after the request, and that data stays on the bus until the next read. The error-correction engine is outside this block; it supplies only the levels and counts.

Top module: `flash_irq_status`

## Requirements
- R1: An event pulse on `evt_i` sets the matching sticky bit. Bit positions are 5 flash ready, 4 controller ready, 3 decode failure, 2 decode error, 1 ECC ready, 0 write-protect fault. The same positions apply to the mask register.
- R2: A read of the sticky register (address 1) returns its value in `bus_rdata_o[5:0]`, with bits 7:6 zero. The same read clears every sticky bit.
- R3: An event that arrives in the same cycle as a sticky read is missing from the returned value. It is set in the sticky register after the clear.
- R4: `irq_o` is high exactly while some sticky bit and its mask bit are both set. It stays high without further events until a sticky read or a mask write removes the condition.
- R5: After reset the mask (address 0) reads zero, the sticky register reads zero and `irq_o` is low. A write to address 0 loads `bus_wdata_i[5:0]` into the mask, and a read of address 0 returns it.
- R6: The live register (address 2) places flash ready at bit 0, controller ready at bit 1, ECC ready at bit 2, errors detected at bit 3 and decoder failure at bit 6. Bit 7 reads zero.
- R7: Live bits 5:4 hold the corrected count `corr_num_i` minus one, so counts 1 to 4 give 0 to 3. Bit 3 is set exactly when the count is nonzero. A count of 0 gives field 0. A count above 4 saturates the field at 3.
- R8: Live ready bits follow their level inputs as sampled at the read. An event pulse does not set them, and reading the live register does not clear them.
- R9: Writes to addresses 1, 2 and 3 change no state. A read of address 3 returns zero.
- R10: Read data appears on `bus_rdata_o` in the cycle after the read request. It holds its value through cycles without a read, including write cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_i | input | 6 | Event pulses, one per sticky bit position |
| nand_rdy_i | input | 1 | Flash device ready level |
| ctl_rdy_i | input | 1 | Controller ready level |
| ecc_rdy_i | input | 1 | ECC result ready level |
| dec_fail_i | input | 1 | Uncorrectable decode level |
| corr_num_i | input | 3 | Number of corrected symbols in the last decode |
| bus_en_i | input | 1 | Bus access request |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Register address (0 mask, 1 sticky, 2 live) |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Level-high interrupt |

## Verification
The assertions check every cycle that:
- events set their sticky bits;
- a sticky read with no coincident event leaves the register and the interrupt clear;
- a coincident event survives the clear;
- the interrupt cannot drop without a read or a mask write;
- read data matches the sticky value and holds between reads;
- the errors-detected flag and the mask load behave as specified.

Some behaviours can only be shown by the directed scenarios:
- the exact bit placement of each event and each live field;
- saturation of the corrected count;
- the interaction between mask writes and the interrupt level;
- the fact that writes to read-only addresses leave the state unchanged.

// File: rtl/fis_pkg.sv
package fis_pkg;
  localparam int EVT_N   = 6;
  localparam int DATA_W  = 8;
  localparam int MAX_CORR = 4;
  localparam int FIELD_W = $clog2(MAX_CORR);

  // sticky / mask bit positions
  localparam int EV_WPF   = 0;
  localparam int EV_ECCR  = 1;
  localparam int EV_DERR  = 2;
  localparam int EV_DFAIL = 3;
  localparam int EV_CTLR  = 4;
  localparam int EV_NANDR = 5;

  // live register bit positions
  localparam int LV_NANDR  = 0;
  localparam int LV_CTLR   = 1;
  localparam int LV_ECCR   = 2;
  localparam int LV_ERRDET = 3;
  localparam int LV_CNT_LO = 4;
  localparam int LV_DFAIL  = 6;

  // register addresses
  localparam int SEL_MASK   = 0;
  localparam int SEL_STICKY = 1;
  localparam int SEL_LIVE   = 2;
endpackage

// File: rtl/fis_rst_sync.sv
module fis_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_n;

  always_comb begin
    sync_n = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_n;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/fis_sticky_bit.sv
module fis_sticky_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q;
  logic q_n;

  // a set in the clearing cycle wins over the clear
  always_comb begin
    q_n = (q_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= 1'b0;
    else        q_q <= q_n;
  end

  assign q_o = q_q;
endmodule

// File: rtl/fis_live_fmt.sv
module fis_live_fmt
  import fis_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic              nand_rdy_i,
  input  logic              ctl_rdy_i,
  input  logic              ecc_rdy_i,
  input  logic              dec_fail_i,
  input  logic [CNT_W-1:0]  corr_num_i,
  output logic [DATA_W-1:0] live_o
);
  logic [FIELD_W-1:0] cnt_field;
  logic               err_det;

  always_comb begin
    err_det = (corr_num_i != '0);
    if (!err_det)
      cnt_field = '0;
    else if (corr_num_i > CNT_W'(MAX_CORR))
      cnt_field = FIELD_W'(MAX_CORR - 1);
    else
      cnt_field = FIELD_W'(corr_num_i - CNT_W'(1));
  end

  always_comb begin
    live_o = '0;
    live_o[LV_NANDR]  = nand_rdy_i;
    live_o[LV_CTLR]   = ctl_rdy_i;
    live_o[LV_ECCR]   = ecc_rdy_i;
    live_o[LV_ERRDET] = err_det;
    live_o[LV_CNT_LO +: FIELD_W] = cnt_field;
    live_o[LV_DFAIL]  = dec_fail_i;
  end
endmodule

// File: rtl/fis_bus_regs.sv
module fis_bus_regs
  import fis_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  input  logic [EVT_N-1:0]  sticky_i,
  input  logic [DATA_W-1:0] live_i,
  output logic [EVT_N-1:0]  mask_o,
  output logic              clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic              rd_en;
  logic              wr_mask;
  logic [EVT_N-1:0]  mask_q, mask_n;
  logic [DATA_W-1:0] rdata_q, rdata_n;

  always_comb begin
    rd_en   = bus_en_i & ~bus_we_i;
    wr_mask = bus_en_i & bus_we_i & (bus_addr_i == ADDR_W'(SEL_MASK));
    clr_o   = rd_en & (bus_addr_i == ADDR_W'(SEL_STICKY));
  end

  always_comb begin
    mask_n = mask_q;
    if (wr_mask) mask_n = bus_wdata_i[EVT_N-1:0];
  end

  always_comb begin
    rdata_n = rdata_q;
    if (rd_en) begin
      case (bus_addr_i)
        ADDR_W'(SEL_MASK):   rdata_n = DATA_W'(mask_q);
        ADDR_W'(SEL_STICKY): rdata_n = DATA_W'(sticky_i);
        ADDR_W'(SEL_LIVE):   rdata_n = live_i;
        default:             rdata_n = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      rdata_q <= '0;
    end else begin
      mask_q  <= mask_n;
      rdata_q <= rdata_n;
    end
  end

  assign mask_o  = mask_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/flash_irq_status.sv
module flash_irq_status
  import fis_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int CNT_W  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EVT_N-1:0]  evt_i,
  input  logic              nand_rdy_i,
  input  logic              ctl_rdy_i,
  input  logic              ecc_rdy_i,
  input  logic              dec_fail_i,
  input  logic [CNT_W-1:0]  corr_num_i,
  input  logic              bus_en_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);
  logic              rst_sync_n;
  logic [EVT_N-1:0]  sticky_q;
  logic [EVT_N-1:0]  mask_q;
  logic              clr_all;
  logic [DATA_W-1:0] live_w;

  fis_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar b = 0; b < EVT_N; b++) begin : g_sticky
    fis_sticky_bit i_bit (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .set_i (evt_i[b]),
      .clr_i (clr_all),
      .q_o   (sticky_q[b])
    );
  end

  fis_live_fmt #(.CNT_W(CNT_W)) i_live (
    .nand_rdy_i (nand_rdy_i),
    .ctl_rdy_i  (ctl_rdy_i),
    .ecc_rdy_i  (ecc_rdy_i),
    .dec_fail_i (dec_fail_i),
    .corr_num_i (corr_num_i),
    .live_o     (live_w)
  );

  fis_bus_regs #(.ADDR_W(ADDR_W)) i_regs (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .bus_en_i    (bus_en_i),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .sticky_i    (sticky_q),
    .live_i      (live_w),
    .mask_o      (mask_q),
    .clr_o       (clr_all),
    .rdata_o     (bus_rdata_o)
  );

  assign irq_o = |(sticky_q & mask_q);
endmodule

// File: rtl/fis_chk.sv
module fis_chk
  import fis_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic [EVT_N-1:0]  evt_i,
  input logic [EVT_N-1:0]  sticky_q,
  input logic [EVT_N-1:0]  mask_q,
  input logic              irq_o,
  input logic              bus_en_i,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [EVT_N-1:0]  wdata_lo,
  input logic [CNT_W-1:0]  corr_num_i,
  input logic [DATA_W-1:0] bus_rdata_o
);
  logic rd_any, rd_sticky, rd_live, wr_any, wr_mask;

  always_comb begin
    rd_any    = bus_en_i & ~bus_we_i;
    wr_any    = bus_en_i & bus_we_i;
    rd_sticky = rd_any & (bus_addr_i == ADDR_W'(SEL_STICKY));
    rd_live   = rd_any & (bus_addr_i == ADDR_W'(SEL_LIVE));
    wr_mask   = wr_any & (bus_addr_i == ADDR_W'(SEL_MASK));
  end

  // R1
  evt_set_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|evt_i) |=> ((sticky_q & $past(evt_i)) == $past(evt_i)));

  // R2
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_sticky && evt_i == '0) |=> (sticky_q == '0));

  // R3
  evt_keep_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_sticky && (|evt_i)) |=> (sticky_q == $past(evt_i)));

  // R4
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_sticky && evt_i == '0) |=> !irq_o);

  // R4
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (irq_o && !rd_sticky && !wr_any) |=> irq_o);

  // R5
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_mask |=> (mask_q == $past(wdata_lo)));

  // R10
  rdata_sticky_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_sticky |=> (bus_rdata_o == DATA_W'($past(sticky_q))));

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rd_any |=> $stable(bus_rdata_o));

  // R7
  errdet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_live |=> (bus_rdata_o[LV_ERRDET] == ($past(corr_num_i) != '0)));

  // R6
  live_top_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_live |=> !bus_rdata_o[DATA_W-1]);
endmodule

bind flash_irq_status fis_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_fis_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .evt_i       (evt_i),
  .sticky_q    (sticky_q),
  .mask_q      (mask_q),
  .irq_o       (irq_o),
  .bus_en_i    (bus_en_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .wdata_lo    (bus_wdata_i[fis_pkg::EVT_N-1:0]),
  .corr_num_i  (corr_num_i),
  .bus_rdata_o (bus_rdata_o)
);

// File: tb/test_flash_irq_status.sv
module test_flash_irq_status;
  logic       clk;
  logic       rst_n;
  logic [5:0] evt_i;
  logic       nand_rdy_i, ctl_rdy_i, ecc_rdy_i, dec_fail_i;
  logic [2:0] corr_num_i;
  logic       bus_en_i, bus_we_i;
  logic [1:0] bus_addr_i;
  logic [7:0] bus_wdata_i;
  logic [7:0] bus_rdata_o;
  logic       irq_o;

  int n_chk = 0;
  int n_fail = 0;

  flash_irq_status i_flash_irq_status (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
    .nand_rdy_i(nand_rdy_i), .ctl_rdy_i(ctl_rdy_i), .ecc_rdy_i(ecc_rdy_i),
    .dec_fail_i(dec_fail_i), .corr_num_i(corr_num_i),
    .bus_en_i(bus_en_i), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog all-R actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_en_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk);
    bus_en_i = 1'b0; bus_we_i = 1'b0; bus_wdata_i = '0;
  endtask

  // read; optional event pulse in the same cycle
  task automatic bus_read_evt(input logic [1:0] a, input logic [5:0] e, output logic [7:0] d);
    @(negedge clk);
    bus_en_i = 1'b1; bus_we_i = 1'b0; bus_addr_i = a; evt_i = e;
    @(negedge clk);
    bus_en_i = 1'b0; evt_i = '0;
    d = bus_rdata_o;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    bus_read_evt(a, 6'h00, d);
  endtask

  task automatic pulse(input logic [5:0] e);
    @(negedge clk);
    evt_i = e;
    @(negedge clk);
    evt_i = '0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R5 irq after reset", {7'b0, irq_o}, 8'h00);
    bus_read(2'd0, d); check("R5 mask reset", d, 8'h00);
    bus_read(2'd1, d); check("R5 sticky reset", d, 8'h00);
  endtask

  task automatic t_each_bit;
    logic [7:0] d;
    for (int i = 0; i < 6; i++) begin
      pulse(6'(1 << i));
      bus_read(2'd1, d); check($sformatf("R1 bit %0d set", i), d, 8'(1 << i));
      bus_read(2'd1, d); check($sformatf("R2 bit %0d cleared", i), d, 8'h00);
    end
    pulse(6'h2A);
    pulse(6'h05);
    bus_read(2'd1, d); check("R1 accumulate", d, 8'h2F);
    bus_read(2'd1, d); check("R2 clear all", d, 8'h00);
  endtask

  task automatic t_coincident;
    logic [7:0] d;
    pulse(6'h01);
    bus_read_evt(2'd1, 6'h10, d); check("R3 read value excludes new", d, 8'h01);
    bus_read(2'd1, d); check("R3 new event kept", d, 8'h10);
    bus_read(2'd1, d); check("R3 then cleared", d, 8'h00);
  endtask

  task automatic t_irq;
    logic [7:0] d;
    bus_write(2'd0, 8'h00);
    pulse(6'h20);
    check("R4 masked no irq", {7'b0, irq_o}, 8'h00);
    bus_write(2'd0, 8'h20);
    check("R4 unmask raises irq", {7'b0, irq_o}, 8'h01);
    repeat (5) @(negedge clk);
    check("R4 irq level holds", {7'b0, irq_o}, 8'h01);
    bus_write(2'd0, 8'h10);
    check("R4 mask other bit drops irq", {7'b0, irq_o}, 8'h00);
    bus_read(2'd0, d); check("R5 mask readback", d, 8'h10);
    bus_write(2'd0, 8'h3F);
    check("R4 full mask raises irq", {7'b0, irq_o}, 8'h01);
    bus_read(2'd1, d); check("R2 sticky read value", d, 8'h20);
    check("R4 irq low after read", {7'b0, irq_o}, 8'h00);
    pulse(6'h01);
    check("R4 wp fault irq", {7'b0, irq_o}, 8'h01);
    bus_read(2'd1, d);
    bus_write(2'd0, 8'h00);
  endtask

  task automatic t_ignored;
    logic [7:0] d;
    pulse(6'h04);
    bus_write(2'd1, 8'h00);
    bus_write(2'd2, 8'hFF);
    bus_write(2'd3, 8'hFF);
    bus_read(2'd0, d); check("R9 mask unchanged", d, 8'h00);
    bus_read(2'd3, d); check("R9 unmapped reads zero", d, 8'h00);
    bus_read(2'd1, d); check("R9 sticky unchanged by write", d, 8'h04);
    bus_write(2'd0, 8'h15);
    repeat (3) @(negedge clk);
    check("R10 rdata held", bus_rdata_o, 8'h04);
    bus_read(2'd0, d); check("R10 read latency", d, 8'h15);
    bus_write(2'd0, 8'h00);
  endtask

  task automatic t_live;
    logic [7:0] d;
    nand_rdy_i = 1; ctl_rdy_i = 0; ecc_rdy_i = 0; dec_fail_i = 0; corr_num_i = 0;
    bus_read(2'd2, d); check("R6 live flash ready bit0", d, 8'h01);
    nand_rdy_i = 0; ctl_rdy_i = 1;
    bus_read(2'd2, d); check("R6 live ctl ready bit1", d, 8'h02);
    ctl_rdy_i = 0; ecc_rdy_i = 1;
    bus_read(2'd2, d); check("R6 live ecc ready bit2", d, 8'h04);
    ecc_rdy_i = 0; dec_fail_i = 1;
    bus_read(2'd2, d); check("R6 live dec fail bit6", d, 8'h40);
    nand_rdy_i = 1; ctl_rdy_i = 1; ecc_rdy_i = 1;
    bus_read(2'd2, d); check("R6 live all flags", d, 8'h47);
    nand_rdy_i = 0; ctl_rdy_i = 0; ecc_rdy_i = 0; dec_fail_i = 0;
  endtask

  task automatic t_count;
    logic [7:0] d;
    logic [7:0] exp_tab [8] = '{8'h00, 8'h08, 8'h18, 8'h28, 8'h38, 8'h38, 8'h38, 8'h38};
    for (int n = 0; n < 8; n++) begin
      corr_num_i = 3'(n);
      bus_read(2'd2, d);
      check($sformatf("R7 corr count %0d", n), d, exp_tab[n]);
    end
    corr_num_i = 0;
  endtask

  task automatic t_live_not_sticky;
    logic [7:0] d;
    pulse(6'h30);
    bus_read(2'd2, d); check("R8 event does not set live", d, 8'h00);
    bus_read(2'd1, d); check("R8 event went to sticky", d, 8'h30);
    nand_rdy_i = 1;
    bus_read(2'd2, d); check("R8 live follows level", d, 8'h01);
    bus_read(2'd2, d); check("R8 live read does not clear", d, 8'h01);
    nand_rdy_i = 0;
    bus_read(2'd2, d); check("R8 live drops with level", d, 8'h00);
  endtask

  initial begin
    rst_n = 0; evt_i = '0; nand_rdy_i = 0; ctl_rdy_i = 0; ecc_rdy_i = 0;
    dec_fail_i = 0; corr_num_i = '0; bus_en_i = 0; bus_we_i = 0;
    bus_addr_i = '0; bus_wdata_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset;
    t_each_bit;
    t_coincident;
    t_irq;
    t_ignored;
    t_live;
    t_count;
    t_live_not_sticky;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule